// File: doc/BRIEF.md
# Prescaled Dual Interval Timer

This block holds three 16-bit down-counters behind a byte-wide register port. Counter 2 divides an incoming master-clock enable. Each time it wraps, it issues a single count enable to counters 0 and 1. Counter 0 runs as a periodic tick source and raises the `irq_tick` level. Counter 1 normally free-runs from 0xFFFF as a timebase. Software freezes a snapshot of it with a latch command and reads the snapshot back one byte at a time. Counter 1 also raises `irq_base` each time it reloads.

Software programs a counter in three steps. A control byte picks the counter and its mode. The low byte of the count follows, then the high byte. Each counter runs either as a rate generator, which reloads its count when it reaches 1, or in software-strobe mode, where it holds still. The two interrupt levels are sticky. They drop only when software writes a one to the matching bit of the clear register. Reloading a counter does not clear them.

Top module: `tmr_prescaled`

## Requirements
- R1: After reset, `irq_tick` and `irq_base` are 0. Every counter holds 0 and does not count until it has been programmed.
- R2: Address map and control byte. Addresses 0, 1 and 2 are the data ports of counters 0, 1 and 2. Address 3 is control and address 4 is the clear register. In a control byte, bits [7:6] select the counter, and select value 3 is ignored. Bits [5:4] give the access code: 11 sets the mode and starts a low/high load, and 00 is a latch command. Bits [3:1] give the mode: 010 is rate generator, and any other value is software strobe.
- R3: A count is written low byte first, then high byte. It takes effect only when the high byte is written. Until then the counter keeps running on its previous count.
- R4: Counter 2 decrements once per cycle with `master_tick` high. When it reaches 1 it reloads and gives counters 0 and 1 one enable. With prescale P and tick count N, `irq_tick` rises after exactly P·N master ticks.
- R5: A written count of 1 is stored as 2, because 2 is the smallest divisor that works.
- R6: When a rate-generator counter 0 or 1 reloads, it sets its interrupt flag. The flag stays high, through further reloads, until it is cleared.
- R7: A write to the clear register with bit 0 set clears `irq_tick`. With bit 1 set it clears `irq_base`. A clear bit of 0 leaves its flag unchanged. If a reload happens in the same cycle as a clear, the reload wins.
- R8: A latch command captures the counter's value. The next two data reads return its low byte and then its high byte. Further latch commands are ignored until both bytes have been read. Without a latch, data reads return the live count, low byte then high byte.
- R9: Selecting software-strobe mode freezes the counter and stops any new interrupt from it.
- R10: Counter 1 loaded with 0xFFFF counts down one step per enable, so the elapsed enables equal 0xFFFF minus the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_tick | input | 1 | Master clock enable that drives counter 2 |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; advances a data port's byte pointer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_tick | output | 1 | Sticky interrupt from counter 0 |
| irq_base | output | 1 | Sticky interrupt from counter 1 |

## Verification
The periodic path is tried with several pairs of prescale and tick count. This shows that the interrupt period is the product P·N and not a sum, and the boundary cycle is checked one tick on each side. Counts of 1 in either stage show whether the divisor-of-two floor is applied. A low byte written alone shows whether a half-written count leaks into the running counter. Latch-and-read sequences tell a frozen snapshot from the live value, and a second latch shows whether it is ignored while a snapshot is pending. Single-bit clear writes show whether the two interrupt flags are cleared separately.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W    = 16;
  localparam int NUM_CNT  = 3;
  localparam int NUM_IRQ  = 2;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = $clog2(NUM_CNT + 1);

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd4;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOAD  = 2'b11;
  localparam logic [2:0] MODE_RATE = 3'b010;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [1:0]       acc;
    logic [2:0]       mode;
    logic             rsvd;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] floor_div(input logic [CNT_W-1:0] v);
    return (v == CNT_W'(1)) ? CNT_W'(2) : v;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ctl_load,
  input  logic             ctl_rate,
  input  logic             ctl_latch,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             reload_evt
);
  logic [CNT_W-1:0] count_q, reload_q, snap_q;
  logic [7:0]       lo_hold_q;
  logic             rate_q, loaded_q, wr_hi_q, rd_hi_q, snap_vld_q;
  logic             step;
  logic [CNT_W-1:0] rd_src;

  assign step       = cnt_en & rate_q & loaded_q;
  assign reload_evt = step & (count_q == CNT_W'(1));
  assign rd_src     = snap_vld_q ? snap_q : count_q;
  assign rdata      = rd_hi_q ? rd_src[CNT_W-1:8] : rd_src[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      reload_q   <= '0;
      snap_q     <= '0;
      lo_hold_q  <= '0;
      rate_q     <= 1'b0;
      loaded_q   <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      snap_vld_q <= 1'b0;
    end else begin
      if (ctl_load) begin
        rate_q  <= ctl_rate;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (ctl_latch && !snap_vld_q) begin
        snap_q     <= count_q;
        snap_vld_q <= 1'b1;
        rd_hi_q    <= 1'b0;
      end
      if (dat_wr) begin
        if (!wr_hi_q) begin
          lo_hold_q <= wdata;
          wr_hi_q   <= 1'b1;
          if (step) count_q <= reload_evt ? reload_q : count_q - CNT_W'(1);
        end else begin
          reload_q <= floor_div({wdata, lo_hold_q});
          count_q  <= floor_div({wdata, lo_hold_q});
          loaded_q <= 1'b1;
          wr_hi_q  <= 1'b0;
        end
      end else if (step) begin
        count_q <= reload_evt ? reload_q : count_q - CNT_W'(1);
      end
      if (dat_rd) begin
        rd_hi_q <= ~rd_hi_q;
        if (rd_hi_q && snap_vld_q) snap_vld_q <= 1'b0;
      end
    end
  end

  // R6: a reload restores the programmed count
  p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && !dat_wr) |=> (count_q == reload_q));

  // R5: a committed count is never 1
  p_min_divisor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && wr_hi_q) |=> (reload_q != CNT_W'(1)));

  // R9: strobe mode freezes the count
  p_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_q && !dat_wr) |=> $stable(count_q));

  // R8: a pending snapshot is not overwritten by a new latch
  p_snap_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_vld_q && !(dat_rd && rd_hi_q)) |=> (snap_vld_q && $stable(snap_q)));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] set_evt,
  input  logic               clr_wr,
  input  logic [NUM_IRQ-1:0] clr_bits,
  output logic [NUM_IRQ-1:0] flags
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       flag_q <= 1'b0;
      else if (set_evt[i])              flag_q <= 1'b1;
      else if (clr_wr && clr_bits[i])   flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;

    // R6: the flag is sticky until a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(clr_wr && clr_bits[i])) |=> flag_q);

    // R7: a clear with no same-cycle reload drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bits[i] && !set_evt[i]) |=> !flag_q);

    // R7: a reload in the clear cycle wins
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flag_q);
  end
endmodule

// File: rtl/tmr_prescaled.sv
module tmr_prescaled
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_tick,
  output logic              irq_base
);
  ctrl_t              ctl;
  logic               ctl_wr, clr_wr;
  logic [NUM_CNT-1:0] en, reload, dwr, drd, cload, clatch;
  logic [7:0]         rd_byte [NUM_CNT];
  logic [NUM_IRQ-1:0] flags;

  assign ctl    = ctrl_t'(bus_wdata);
  assign ctl_wr = bus_wr && (bus_addr == A_CTRL);
  assign clr_wr = bus_wr && (bus_addr == A_CLEAR);

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic hit_ctl;
    assign hit_ctl   = ctl_wr && (ctl.sel == SEL_W'(c));
    assign cload[c]  = hit_ctl && (ctl.acc == ACC_LOAD);
    assign clatch[c] = hit_ctl && (ctl.acc == ACC_LATCH);
    assign dwr[c]    = bus_wr && (bus_addr == ADDR_W'(c));
    assign drd[c]    = bus_rd && (bus_addr == ADDR_W'(c));
    if (c == NUM_CNT - 1) begin : g_pre
      assign en[c] = master_tick;
    end else begin : g_div
      assign en[c] = reload[NUM_CNT-1];
    end

    tmr_counter u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_en     (en[c]),
      .ctl_load   (cload[c]),
      .ctl_rate   (ctl.mode == MODE_RATE),
      .ctl_latch  (clatch[c]),
      .dat_wr     (dwr[c]),
      .dat_rd     (drd[c]),
      .wdata      (bus_wdata),
      .rdata      (rd_byte[c]),
      .reload_evt (reload[c])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int c = 0; c < NUM_CNT; c++)
      if (bus_addr == ADDR_W'(c)) bus_rdata = rd_byte[c];
  end

  tmr_irq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (reload[NUM_IRQ-1:0]),
    .clr_wr   (clr_wr),
    .clr_bits (bus_wdata[NUM_IRQ-1:0]),
    .flags    (flags)
  );

  assign irq_tick = flags[0];
  assign irq_base = flags[1];

  // R4: counters 0 and 1 advance only on a prescaler wrap
  p_prescale_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload[0] || reload[1]) |-> reload[NUM_CNT-1]);

  // R4: the prescaler wraps only on a master tick
  p_master_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload[NUM_CNT-1] |-> master_tick);
endmodule

// File: tb/tmr_prescaled_bench.sv
module tmr_prescaled_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_tick, irq_base;
  int         n_run = 0, n_fail = 0;
  logic [7:0] lo, hi, lo2, hi2;

  always #10 clk = ~clk;

  tmr_prescaled u_tmr_prescaled (.*);

  // {prescale, tick count, master ticks, expected irq_tick}
  localparam logic [31:0] VEC [8] = '{
    {8'd2, 8'd3, 8'd5, 8'd0}, {8'd2, 8'd3, 8'd6, 8'd1},
    {8'd4, 8'd2, 8'd7, 8'd0}, {8'd4, 8'd2, 8'd8, 8'd1},
    {8'd1, 8'd3, 8'd5, 8'd0}, {8'd1, 8'd3, 8'd6, 8'd1},
    {8'd3, 8'd1, 8'd5, 8'd0}, {8'd3, 8'd1, 8'd6, 8'd1}};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic load(input int sel, input logic [15:0] v);
    wr(3'd3, 8'(sel << 6) | 8'h34);
    wr(3'(sel), v[7:0]);
    wr(3'(sel), v[15:8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); master_tick = 1'b1;
      @(negedge clk); master_tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq_tick", irq_tick, 0);
    chk("R1 irq_base", irq_base, 0);
    rd(3'd1, lo); rd(3'd1, hi);
    chk("R1 count1", {hi, lo}, 0);
    ticks(5);
    chk("R1 idle irq", irq_tick, 0);

    // R4, R5, R6: walk prescale/count vectors
    foreach (VEC[k]) begin
      load(2, 16'(VEC[k][31:24]));
      load(0, 16'(VEC[k][23:16]));
      wr(3'd4, 8'h03);
      ticks(int'(VEC[k][15:8]));
      chk($sformatf("R4/R5/R6 vec%0d", k), irq_tick, int'(VEC[k][7:0]));
    end

    // R3: a lone low byte leaves the old count running
    load(2, 16'd2); load(0, 16'd2); wr(3'd4, 8'h03);
    wr(3'd0, 8'h05);
    ticks(4);
    chk("R3 old count", irq_tick, 1);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h01);
    ticks(9);
    chk("R3 new count early", irq_tick, 0);
    ticks(1);
    chk("R3 new count", irq_tick, 1);
    ticks(10);
    chk("R6 sticky", irq_tick, 1);

    // R7: separate clear bits
    load(2, 16'd2); load(0, 16'd2); load(1, 16'd3); wr(3'd4, 8'h03);
    ticks(6);
    chk("R7 both set tick", irq_tick, 1);
    chk("R7 both set base", irq_base, 1);
    wr(3'd4, 8'h02);
    chk("R7 bit1 clears base", irq_base, 0);
    chk("R7 bit1 keeps tick", irq_tick, 1);
    wr(3'd4, 8'h01);
    chk("R7 bit0 clears tick", irq_tick, 0);

    // R9: strobe mode freezes counter 0
    wr(3'd3, 8'h38);
    rd(3'd0, lo); rd(3'd0, hi);
    wr(3'd4, 8'h03);
    ticks(20);
    rd(3'd0, lo2); rd(3'd0, hi2);
    chk("R9 frozen", {hi2, lo2}, {hi, lo});
    chk("R9 no irq", irq_tick, 0);

    // R8, R10: latch and read the free-running timebase
    load(2, 16'd2); load(1, 16'hFFFF);
    ticks(10);
    wr(3'd3, 8'h40);
    ticks(4);
    wr(3'd3, 8'h40);
    rd(3'd1, lo); rd(3'd1, hi);
    chk("R8 latched", {hi, lo}, 16'hFFFA);
    chk("R10 elapsed", 16'hFFFF - {hi, lo}, 5);
    rd(3'd1, lo); rd(3'd1, hi);
    chk("R8 live", {hi, lo}, 16'hFFF8);
    // R2: select value 3 is ignored
    wr(3'd3, 8'hC0);
    rd(3'd1, lo); rd(3'd1, hi);
    chk("R2 sel3 ignored", {hi, lo}, 16'hFFF8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule